// File: doc/BRIEF.md
# Dual-mode multiplexed bus slave

This block is the peripheral end of an 8-bit multiplexed address/data bus. A host places an address on the bus during an address-strobe pulse and then transfers one byte to or from a 128-byte register array inside the block. A pin-strapped mode input picks one of two timing conventions. In the level-plus-strobe convention, a read/write level says which way the transfer goes and a positive data strobe times it. In the separate-strobes convention, an active-low write strobe and an active-low output enable each time one direction.

Every bus input, including the data lines, is resampled by the system clock through a two-flop synchronizer, and the access engine works on edges of the synchronized strobes. A captured address becomes usable for one access only. The block discards it when the next address-strobe cycle begins, when chip select goes inactive, and after the access it served. A power-fail input acts as a forced-inactive chip select, so the array cannot be reached while that input is set.

Top module: `mbus_slave`

## Requirements
- R1: After reset, bus_oe_o is 0, bus_o is 0 and every array entry reads back as 0x00.
- R2: With mode_i=1, a byte on bus_i is written to the latched address on the falling edge of ds_i while rw_i is 0.
- R3: With mode_i=1, when ds_i is 1 and rw_i is 1 the block drives the addressed byte with bus_oe_o=1. Once ds_i returns to 0, bus_oe_o is 0 and bus_o is 0x00.
- R4: With mode_i=0, the byte on bus_i is written to the latched address on the rising edge of rw_i (active-low write strobe).
- R5: With mode_i=0, the block drives the addressed byte with bus_oe_o=1 only while ds_i is 0 (active-low output enable).
- R6: A falling edge of as_i latches bus_i[6:0] as the address. A rising edge of as_i clears it, so a strobe given while as_i stays high has no effect.
- R7: If cs_ni is 1 at the falling edge of as_i, the following strobes do nothing even if cs_ni is 0 during them.
- R8: If cs_ni is 1 during a data, read or write strobe, that strobe does nothing, and the address stays unusable until a new as_i cycle.
- R9: While pwr_fail_i is 1, no write changes the array and bus_oe_o stays 0.
- R10: Only one access is performed per as_i cycle; a second write strobe without a new address strobe leaves the array unchanged.
- R11: bus_oe_o is 0 whenever no qualified read is in progress, including during writes and idle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all bus inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1: level-plus-strobe timing, 0: separate active-low strobes |
| pwr_fail_i | input | 1 | Power-fail flag; blocks all access while 1 |
| cs_ni | input | 1 | Active-low chip select |
| as_i | input | 1 | Address strobe; falling edge latches the address |
| rw_i | input | 1 | Read/write level (mode 1) or active-low write strobe (mode 0) |
| ds_i | input | 1 | Data strobe (mode 1) or active-low output enable (mode 0) |
| bus_i | input | 8 | Multiplexed address/data input |
| bus_o | output | 8 | Read data, 0 when not driving |
| bus_oe_o | output | 1 | Output enable for bus_o |

## Verification
If the address-valid state is wrong, it shows on the next strobe. A stale valid flag lets an ignored write land, and a later read of that address returns the new byte. A valid flag that was lost blocks a read, so bus_oe_o stays 0 within a few cycles of the strobe. A wrong latched address shows up as read-back data from another entry. Every write is therefore followed by a read of the same entry, and blocked cycles are followed by a read of the entry they would have touched.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 128;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  typedef enum logic {MODE_SEP = 1'b0, MODE_LVL = 1'b1} bus_mode_e;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_eff_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_in_i,
  output logic              we_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o
);
  import mbus_pkg::*;

  logic as_d, ds_d, rw_d, valid_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_d <= 1'b0;
      ds_d <= 1'b0;
      rw_d <= 1'b0;
    end else begin
      as_d <= as_i;
      ds_d <= ds_i;
      rw_d <= rw_i;
    end
  end

  logic as_rise, as_fall, ds_rise, ds_fall, rw_rise, ok, done;
  assign as_rise = as_i & ~as_d;
  assign as_fall = ~as_i & as_d;
  assign ds_rise = ds_i & ~ds_d;
  assign ds_fall = ~ds_i & ds_d;
  assign rw_rise = rw_i & ~rw_d;
  assign ok      = valid_q & cs_eff_i;

  always_comb begin
    if (mode_i == MODE_LVL) begin
      rd_o = ok & ds_i & rw_i;
      we_o = ok & ds_fall & ~rw_i;
      done = ds_fall;
    end else begin
      rd_o = ok & ~ds_i;
      we_o = ok & rw_rise;
      done = ds_rise | rw_rise;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (as_rise) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (as_fall) begin
      valid_q <= cs_eff_i;
      addr_q  <= addr_in_i;
    end else if (!cs_eff_i || done) begin
      valid_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;

  assert_as_high_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_d |-> (!we_o && !rd_o));
  assert_single_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (!valid_q && !we_o));
  assert_lvl_write_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && mode_i) |-> $past(ds_i) && !ds_i);
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              pwr_fail_i,
  input  logic              cs_ni,
  input  logic              as_i,
  input  logic              rw_i,
  input  logic              ds_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  localparam int unsigned SW = DATA_W + 5;
  localparam logic [SW-1:0] SRST = {1'b0, 1'b1, 3'b000, {DATA_W{1'b0}}};

  logic [SW-1:0] raw, syn;
  logic pf_s, csn_s, as_s, ds_s, rw_s;
  logic [DATA_W-1:0] bus_s, rdata;
  logic [ADDR_W-1:0] addr;
  logic we, rd, cs_eff;

  assign raw = {pwr_fail_i, cs_ni, as_i, ds_i, rw_i, bus_i};

  mbus_sync #(.W(SW), .RST_VAL(SRST)) i_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  assign {pf_s, csn_s, as_s, ds_s, rw_s, bus_s} = syn;
  assign cs_eff = ~csn_s & ~pf_s;

  mbus_strobe #(.ADDR_W(ADDR_W)) i_strobe (
    .clk_i, .rst_ni, .mode_i, .cs_eff_i(cs_eff),
    .as_i(as_s), .ds_i(ds_s), .rw_i(rw_s),
    .addr_in_i(bus_s[ADDR_W-1:0]),
    .we_o(we), .rd_o(rd), .addr_o(addr)
  );

  mbus_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_regs (
    .clk_i, .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(bus_s), .rdata_o(rdata)
  );

  assign bus_oe_o = rd;
  assign bus_o    = rd ? rdata : '0;

  assert_pf_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_s |-> !we);
  assert_pf_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_s |-> !bus_oe_o);
  assert_no_drive_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !bus_oe_o);
  assert_cs_off_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |-> (!we && !bus_oe_o));
endmodule

// File: tb/test_mbus_slave.sv
module test_mbus_slave;
  logic clk = 0, rst_n = 0;
  logic mode = 1, pf = 0, cs_n = 1, as_s = 0, rw = 1, ds = 0;
  logic [7:0] bus_in = 0, bus_out;
  logic oe;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_mem [128];

  always #5 clk = ~clk;

  mbus_slave i_mbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pwr_fail_i(pf), .cs_ni(cs_n),
    .as_i(as_s), .rw_i(rw), .ds_i(ds), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe)
  );

  task automatic step();
    repeat (5) @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // one address cycle followed by nstr strobes
  task automatic cycle(input bit wr, input logic [6:0] a, input logic [7:0] d,
                       input bit cs_as, input bit cs_st, input bit as_hi, input int nstr,
                       output logic oe_s, output logic [7:0] q_s, output logic oe_after);
    oe_s = 0; q_s = 0;
    cs_n = !cs_as; bus_in = {1'b0, a}; as_s = 1; step();
    as_s = 0; step();
    if (as_hi) begin as_s = 1; step(); end
    cs_n = !cs_st;
    for (int k = 0; k < nstr; k++) begin
      if (mode) begin
        rw = !wr; if (wr) bus_in = d; ds = 1; step();
        if (!wr) begin oe_s = oe; q_s = bus_out; end
        ds = 0; step(); rw = 1;
      end else if (wr) begin
        bus_in = d; rw = 0; step(); rw = 1; step();
      end else begin
        ds = 0; step(); oe_s = oe; q_s = bus_out; ds = 1; step();
      end
    end
    oe_after = oe;
    cs_n = 1;
    if (as_hi) begin as_s = 0; step(); end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic o, oa; logic [7:0] q;
    cycle(1, a, d, 1, 1, 0, 1, o, q, oa);
    exp_mem[a] = d;
  endtask

  task automatic read_check(input logic [6:0] a, input string tag);
    logic o, oa; logic [7:0] q;
    cycle(0, a, 0, 1, 1, 0, 1, o, q, oa);
    check(o === 1'b1, {tag, " oe"}, o, 1);
    check(q === exp_mem[a], {tag, " data"}, q, exp_mem[a]);
    check(oa === 1'b0, "R11 oe after read", oa, 0);
  endtask

  task automatic set_mode(input bit m);
    mode = m; ds = m ? 1'b0 : 1'b1; rw = 1; step();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic o, oa; logic [7:0] q;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 128; i++) exp_mem[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    step();
    // R1
    check(oe === 0, "R1 oe", oe, 0);
    check(bus_out === 0, "R1 bus_o", bus_out, 0);
    read_check(7'd0, "R1 reset read 0");
    read_check(7'd127, "R1 reset read 127");

    // level-plus-strobe mode: R2 R3
    set_mode(1);
    do_write(7'h12, 8'hA5);
    read_check(7'h12, "R2 R3 lvl rw");
    do_write(7'h7F, 8'hFF);
    read_check(7'h7F, "R2 lvl top");
    for (int i = 0; i < 30; i++) begin
      logic [6:0] a; logic [7:0] d;
      a = 7'($urandom % 128); d = 8'($urandom);
      do_write(a, d);
      read_check(a, "R2 R3 lvl random");
    end
    // R11 during write strobe
    cs_n = 0; bus_in = 8'h05; as_s = 1; step(); as_s = 0; step();
    bus_in = 8'h3C; rw = 0; ds = 1; step();
    check(oe === 0, "R11 no drive during write", oe, 0);
    ds = 0; step(); rw = 1; cs_n = 1; step();
    exp_mem[5] = 8'h3C;
    read_check(7'h05, "R2 write seen");

    // R6 address cleared by as rise
    cycle(1, 7'h12, 8'h11, 1, 1, 1, 1, o, q, oa);
    read_check(7'h12, "R6 lvl write ignored");
    cycle(0, 7'h12, 0, 1, 1, 1, 1, o, q, oa);
    check(o === 0, "R6 lvl read ignored", o, 0);
    // R7
    cycle(1, 7'h12, 8'h22, 0, 1, 0, 1, o, q, oa);
    read_check(7'h12, "R7 lvl cs off at as");
    // R8
    cycle(1, 7'h12, 8'h33, 1, 0, 0, 1, o, q, oa);
    read_check(7'h12, "R8 lvl cs off at ds");
    cycle(0, 7'h12, 0, 1, 0, 0, 1, o, q, oa);
    check(o === 0, "R8 lvl read cs off", o, 0);
    // R10
    cycle(1, 7'h20, 8'h44, 1, 1, 0, 1, o, q, oa);
    exp_mem[7'h20] = 8'h44;
    cs_n = 0; bus_in = 8'h99; rw = 0; ds = 1; step(); ds = 0; step(); rw = 1; cs_n = 1; step();
    read_check(7'h20, "R10 lvl second strobe ignored");
    // R9
    pf = 1; step();
    cycle(1, 7'h20, 8'h55, 1, 1, 0, 1, o, q, oa);
    cycle(0, 7'h20, 0, 1, 1, 0, 1, o, q, oa);
    check(o === 0, "R9 lvl read blocked", o, 0);
    pf = 0; step();
    read_check(7'h20, "R9 lvl write blocked");

    // separate-strobes mode: R4 R5
    set_mode(0);
    do_write(7'h12, 8'h5A);
    read_check(7'h12, "R4 R5 sep rw");
    for (int i = 0; i < 30; i++) begin
      logic [6:0] a; logic [7:0] d;
      a = 7'($urandom % 128); d = 8'($urandom);
      do_write(a, d);
      read_check(a, "R4 R5 sep random");
    end
    check(oe === 0, "R5 idle no drive", oe, 0);
    cycle(1, 7'h30, 8'h66, 1, 1, 1, 1, o, q, oa);
    read_check(7'h30, "R6 sep write ignored");
    cycle(1, 7'h30, 8'h77, 0, 1, 0, 1, o, q, oa);
    read_check(7'h30, "R7 sep cs off at as");
    cycle(1, 7'h30, 8'h88, 1, 0, 0, 1, o, q, oa);
    read_check(7'h30, "R8 sep cs off at strobe");
    cycle(1, 7'h31, 8'h12, 1, 1, 0, 2, o, q, oa);
    exp_mem[7'h31] = 8'h12;
    read_check(7'h31, "R10 sep double strobe");
    pf = 1; step();
    cycle(1, 7'h31, 8'hEE, 1, 1, 0, 1, o, q, oa);
    cycle(0, 7'h31, 0, 1, 1, 0, 1, o, q, oa);
    check(o === 0, "R9 sep read blocked", o, 0);
    check(q === 0, "R9 sep bus_o zero", q, 0);
    pf = 0; step();
    read_check(7'h31, "R9 sep write blocked");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule